// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide flash memory with 256K locations. It samples a host bus clock by clock: an 18-bit address, a data byte, a select line, a read strobe, a write strobe and a flag that says the programming supply is up. It turns the host's writes into one- and two-write command sequences. It chooses what a read returns: array data, a fixed identifier byte, or a status byte. It also launches program and erase jobs on a job handshake that an external array model serves.

The strobes are active high. A write begins when both the select line and the write strobe are high, and it ends when either one drops. The address is taken when the write begins. The data byte and the command take effect when the write ends. Reads are combinational from the address while both select and read are high, so the array behind the block returns its byte through `arr_rdata` in the same cycle. A job runs until the array side reports `job_done`. An erase job takes two such handshakes: the first for the fill-with-zeros pass and the second for the erase pass.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `vpp_hi` is low, the block returns to array read within one clock. `busy` and `fail` are cleared, any running job is dropped, and every write is ignored. A 90h written with the supply low therefore leaves address 0 reading array data.
- R2: A write captures the address on the first clock that sees the write active. It captures the data byte on the first clock that sees the write inactive again, and the command acts at that point. Address changes later in the pulse have no effect.
- R3: Writing 00h selects array read, which then persists. Any first write that is not a recognised command also selects array read. Array reads drive all eight bits (`dout_oe`=FFh) with `arr_rdata`.
- R4: Writing 90h selects identifier read, which persists until another command. Address 0 reads C2h, address 1 reads 3Ch, and any other address reads 00h, all with `dout_oe`=FFh.
- R5: The write pair 30h, 30h starts a chip erase. `job_start` is high for exactly one clock, with `job_kind`=2 and `job_addr`=0.
- R6: The write pair 20h, D0h starts a block erase. `job_kind`=3 and `job_addr` is the address of the D0h write.
- R7: 40h followed by any write of a byte other than FFh starts a byte program. `job_kind`=1, `job_phase`=3, and `job_addr`/`job_data` hold the address and data of the second write.
- R8: A second write that does not complete a legal pair returns the block to array read and raises no `job_start`.
- R9: FFh written twice after any set-up write (30h, 20h or 40h) cancels the set-up. No job starts and the block is in array read.
- R10: `busy` rises with `job_start` and stays high until the final `job_done`. Writes made while busy are ignored.
- R11: An erase job reports `job_phase`=1 (fill with zeros) first. It moves to `job_phase`=2 (erase) on the first `job_done` and ends on the second. A program job ends on its single `job_done`.
- R12: While busy, a read drives only bits 7 and 6 (`dout_oe`=C0h, bits 5..0 read 0). Bit 6 reads 0 on the first read after the start and inverts on each later read. Bit 7 is the inverse of bit 7 of the program data, or 0 during an erase.
- R13: A `job_done` without `job_fail` returns the block to array read with `busy` low. With `job_fail`, `fail` rises and every write is ignored except FFh written twice, which clears `fail` and selects array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host select |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| vpp_hi | input | 1 | Programming supply is up |
| addr | input | 18 | Host address |
| din | input | 8 | Host write data |
| arr_rdata | input | 8 | Array byte at `addr` |
| dout | output | 8 | Read data |
| dout_oe | output | 8 | Per-bit output drive enable |
| job_start | output | 1 | One-clock job launch strobe |
| job_kind | output | 2 | 0 none, 1 program, 2 chip erase, 3 block erase |
| job_phase | output | 2 | 0 idle, 1 zero fill, 2 erase, 3 program |
| job_addr | output | 18 | Job target address |
| job_data | output | 8 | Program data |
| job_done | input | 1 | Array side finished the current phase |
| job_fail | input | 1 | Qualifies `job_done` as a failure |
| busy | output | 1 | Job in progress |
| fail | output | 1 | Last job failed, awaiting clear |

## Verification
The bench tests the write timing by moving the address after the write begins and holding data just past its end. A block that latched late would report the wrong job address. It reads status three times in a row, so a toggle that is not cleared at the start, or that flips on clocks rather than on reads, shows the wrong bit 6 sequence. It issues broken pairs, double-FFh aborts, writes while busy, writes while failed and writes with the supply low, each of which a faulty decoder would turn into a spurious start or a stuck mode. It also drives random command pairs against a predicted start outcome.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int DW = 8;

    typedef enum logic [3:0] {
        ST_ARRAY, ST_IDENT, ST_SU_CHIP, ST_SU_BLK, ST_SU_PROG,
        ST_ABORT1, ST_BUSY, ST_FAIL, ST_FAIL_FF
    } fcc_state_e;

    typedef enum logic [1:0] {JK_NONE = 2'd0, JK_PROG = 2'd1, JK_CHIP = 2'd2, JK_BLOCK = 2'd3} job_kind_e;
    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ZERO = 2'd1, PH_ERASE = 2'd2, PH_PROG = 2'd3} job_phase_e;

    localparam logic [DW-1:0] CMD_READ   = 8'h00;
    localparam logic [DW-1:0] CMD_IDENT  = 8'h90;
    localparam logic [DW-1:0] CMD_CHIP   = 8'h30;
    localparam logic [DW-1:0] CMD_BLK    = 8'h20;
    localparam logic [DW-1:0] CMD_BLK_GO = 8'hD0;
    localparam logic [DW-1:0] CMD_PROG   = 8'h40;
    localparam logic [DW-1:0] CMD_ABORT  = 8'hFF;
endpackage

// File: rtl/fcc_wr_capture.sv
module fcc_wr_capture
    import fcc_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_hi,
    input  logic          bus_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          commit,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);
    typedef struct packed {
        logic          wr;
        logic          commit;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic wr_act;

    assign wr_act = bus_sel & wr_en & vpp_hi;

    always_comb begin
        cap_d        = cap_q;
        cap_d.wr     = wr_act;
        cap_d.commit = 1'b0;
        if (wr_act && !cap_q.wr) begin
            cap_d.addr = addr;
        end
        if (!wr_act && cap_q.wr) begin
            cap_d.commit = 1'b1;
            cap_d.data   = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign commit   = cap_q.commit;
    assign cap_addr = cap_q.addr;
    assign cap_data = cap_q.data;

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R2
    AST_ADDR_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.wr && wr_act |=> $stable(cap_addr)); // R2
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_hi,
    input  logic          commit,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          job_done,
    input  logic          job_fail,
    output logic          ident,
    output logic          job_start,
    output logic [1:0]    job_kind,
    output logic [1:0]    job_phase,
    output logic [AW-1:0] job_addr,
    output logic [DW-1:0] job_data,
    output logic          busy,
    output logic          fail
);
    typedef struct packed {
        fcc_state_e    st;
        job_kind_e     kind;
        job_phase_e    phase;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          start;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic fcc_state_e first_write(logic [DW-1:0] c);
        case (c)
            CMD_IDENT: return ST_IDENT;
            CMD_CHIP:  return ST_SU_CHIP;
            CMD_BLK:   return ST_SU_BLK;
            CMD_PROG:  return ST_SU_PROG;
            default:   return ST_ARRAY;
        endcase
    endfunction

    function automatic seq_t launch(seq_t s, job_kind_e k, job_phase_e p,
                                    logic [AW-1:0] a, logic [DW-1:0] d);
        seq_t r = s;
        r.st    = ST_BUSY;
        r.kind  = k;
        r.phase = p;
        r.addr  = a;
        r.data  = d;
        r.start = 1'b1;
        return r;
    endfunction

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        if (!vpp_hi) begin
            seq_d.st    = ST_ARRAY;
            seq_d.kind  = JK_NONE;
            seq_d.phase = PH_IDLE;
        end else begin
            case (seq_q.st)
                ST_BUSY: begin
                    if (job_done) begin
                        if (job_fail || seq_q.phase != PH_ZERO) begin
                            seq_d.st    = job_fail ? ST_FAIL : ST_ARRAY;
                            seq_d.kind  = JK_NONE;
                            seq_d.phase = PH_IDLE;
                        end else begin
                            seq_d.phase = PH_ERASE;
                        end
                    end
                end
                ST_FAIL: begin
                    if (commit && cmd_data == CMD_ABORT) seq_d.st = ST_FAIL_FF;
                end
                ST_FAIL_FF: begin
                    if (commit) seq_d.st = (cmd_data == CMD_ABORT) ? ST_ARRAY : ST_FAIL;
                end
                ST_SU_CHIP: begin
                    if (commit) begin
                        if (cmd_data == CMD_CHIP)       seq_d = launch(seq_q, JK_CHIP, PH_ZERO, '0, '0);
                        else if (cmd_data == CMD_ABORT) seq_d.st = ST_ABORT1;
                        else                            seq_d.st = ST_ARRAY;
                    end
                end
                ST_SU_BLK: begin
                    if (commit) begin
                        if (cmd_data == CMD_BLK_GO)     seq_d = launch(seq_q, JK_BLOCK, PH_ZERO, cmd_addr, '0);
                        else if (cmd_data == CMD_ABORT) seq_d.st = ST_ABORT1;
                        else                            seq_d.st = ST_ARRAY;
                    end
                end
                ST_SU_PROG: begin
                    if (commit) begin
                        if (cmd_data == CMD_ABORT) seq_d.st = ST_ABORT1;
                        else seq_d = launch(seq_q, JK_PROG, PH_PROG, cmd_addr, cmd_data);
                    end
                end
                ST_ABORT1: begin
                    if (commit) seq_d.st = ST_ARRAY;
                end
                default: begin
                    if (commit) seq_d.st = first_write(cmd_data);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_ARRAY, kind: JK_NONE, phase: PH_IDLE, addr: '0, data: '0, start: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ident     = (seq_q.st == ST_IDENT);
    assign job_start = seq_q.start;
    assign job_kind  = seq_q.kind;
    assign job_phase = seq_q.phase;
    assign job_addr  = seq_q.addr;
    assign job_data  = seq_q.data;
    assign busy      = (seq_q.st == ST_BUSY);
    assign fail      = (seq_q.st == ST_FAIL) || (seq_q.st == ST_FAIL_FF);

    AST_VPP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi |=> !busy && !fail && !job_start); // R1
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start); // R5
    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> job_start); // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !job_done && vpp_hi |=> busy); // R10
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && seq_q.phase != $past(seq_q.phase)
        |-> $past(seq_q.phase) == PH_ZERO && seq_q.phase == PH_ERASE); // R11
    AST_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !busy && !job_start); // R13
endmodule

// File: rtl/fcc_rd_mux.sv
module fcc_rd_mux
    import fcc_pkg::*;
#(
    parameter int              AW       = 18,
    parameter logic [DW-1:0]   MFR_CODE = 8'hC2,
    parameter logic [DW-1:0]   DEV_CODE = 8'h3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          rd_en,
    input  logic          busy,
    input  logic          job_start,
    input  logic          ident,
    input  logic          prog_job,
    input  logic          prog_bit7,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] dout_oe
);
    localparam int TGL_BIT  = 6;
    localparam int POLL_BIT = 7;
    localparam logic [DW-1:0] STATUS_OE = (DW'(1) << TGL_BIT) | (DW'(1) << POLL_BIT);

    typedef struct packed {
        logic rd;
        logic tgl;
    } rd_t;

    rd_t  rd_d, rd_q;
    logic rd_act;

    assign rd_act = bus_sel & rd_en;

    always_comb begin
        rd_d    = rd_q;
        rd_d.rd = rd_act;
        if (job_start) begin
            rd_d.tgl = 1'b0;
        end else if (busy && rd_q.rd && !rd_act) begin
            rd_d.tgl = ~rd_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        dout    = '0;
        dout_oe = '0;
        if (rd_act) begin
            if (busy) begin
                dout[POLL_BIT] = prog_job & ~prog_bit7;
                dout[TGL_BIT]  = rd_q.tgl;
                dout_oe        = STATUS_OE;
            end else if (ident) begin
                dout_oe = '1;
                if (addr == AW'(0))      dout = MFR_CODE;
                else if (addr == AW'(1)) dout = DEV_CODE;
            end else begin
                dout_oe = '1;
                dout    = arr_rdata;
            end
        end
    end

    AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !job_start && rd_q.rd && !rd_act |=> rd_q.tgl != $past(rd_q.tgl)); // R12
    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !job_start && !(rd_q.rd && !rd_act) |=> $stable(rd_q.tgl)); // R12
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int            ADDR_W   = 18,
    parameter logic [7:0]    MFR_CODE = 8'hC2,
    parameter logic [7:0]    DEV_CODE = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              vpp_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        dout,
    output logic [7:0]        dout_oe,
    output logic              job_start,
    output logic [1:0]        job_kind,
    output logic [1:0]        job_phase,
    output logic [ADDR_W-1:0] job_addr,
    output logic [7:0]        job_data,
    input  logic              job_done,
    input  logic              job_fail,
    output logic              busy,
    output logic              fail
);
    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [DW-1:0]     cap_data;
    logic              ident;

    fcc_wr_capture #(.AW(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .vpp_hi   (vpp_hi),
        .bus_sel  (bus_sel),
        .wr_en    (wr_en),
        .addr     (addr),
        .din      (din),
        .commit   (commit),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    fcc_seq #(.AW(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vpp_hi    (vpp_hi),
        .commit    (commit),
        .cmd_addr  (cap_addr),
        .cmd_data  (cap_data),
        .job_done  (job_done),
        .job_fail  (job_fail),
        .ident     (ident),
        .job_start (job_start),
        .job_kind  (job_kind),
        .job_phase (job_phase),
        .job_addr  (job_addr),
        .job_data  (job_data),
        .busy      (busy),
        .fail      (fail)
    );

    fcc_rd_mux #(.AW(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .rd_en     (rd_en),
        .busy      (busy),
        .job_start (job_start),
        .ident     (ident),
        .prog_job  (job_kind == JK_PROG),
        .prog_bit7 (job_data[7]),
        .addr      (addr),
        .arr_rdata (arr_rdata),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0, vpp_hi = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  arr_rdata;
    logic [7:0]  dout, dout_oe;
    logic        job_start, busy, fail;
    logic [1:0]  job_kind, job_phase;
    logic [17:0] job_addr;
    logic [7:0]  job_data;
    logic        job_done = 1'b0, job_fail = 1'b0;

    int n_chk = 0, n_fail = 0, n_starts = 0;
    logic [1:0]  s_kind, s_phase;
    logic [17:0] s_addr;
    logic [7:0]  s_data;
    bit fin = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] arr_model(logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h5C;
    endfunction

    assign arr_rdata = arr_model(addr);

    flash_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .rd_en(rd_en), .wr_en(wr_en),
        .vpp_hi(vpp_hi), .addr(addr), .din(din), .arr_rdata(arr_rdata),
        .dout(dout), .dout_oe(dout_oe), .job_start(job_start), .job_kind(job_kind),
        .job_phase(job_phase), .job_addr(job_addr), .job_data(job_data),
        .job_done(job_done), .job_fail(job_fail), .busy(busy), .fail(fail)
    );

    always @(negedge clk) begin
        if (rst_n && job_start) begin
            n_starts++;
            s_kind  = job_kind;
            s_phase = job_phase;
            s_addr  = job_addr;
            s_data  = job_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; bus_sel = 1'b1; wr_en = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b0; bus_sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [17:0] a, output logic [7:0] d, output logic [7:0] oe);
        @(negedge clk);
        addr = a; bus_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        d = dout; oe = dout_oe;
        rd_en = 1'b0; bus_sel = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_job(input logic f);
        @(negedge clk);
        job_done = 1'b1; job_fail = f;
        @(negedge clk);
        job_done = 1'b0; job_fail = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, oe;
        int s0;
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset busy", busy, 0);
        chk("R1 reset fail", fail, 0);
        chk("R1 reset kind", job_kind, 0);
        bus_read(18'h00005, rd, oe);
        chk("R3 reset array data", rd, arr_model(18'h00005));
        chk("R3 reset array oe", oe, 8'hFF);

        // identifier mode
        bus_write(18'h1234, 8'h90);
        bus_read(18'h0, rd, oe);  chk("R4 id addr0", rd, 8'hC2);
        bus_read(18'h1, rd, oe);  chk("R4 id addr1", rd, 8'h3C);
        chk("R4 id oe", oe, 8'hFF);
        bus_read(18'h7, rd, oe);  chk("R4 id other", rd, 8'h00);
        bus_read(18'h0, rd, oe);  chk("R4 id persists", rd, 8'hC2);

        // array mode and unknown first code
        bus_write(18'h0, 8'h00);
        bus_read(18'h0, rd, oe);  chk("R3 array after 00h", rd, arr_model(18'h0));
        bus_read(18'h1, rd, oe);  chk("R3 array persists", rd, arr_model(18'h1));
        bus_write(18'h0, 8'h90);
        bus_write(18'h0, 8'h55);
        bus_read(18'h1, rd, oe);  chk("R3 unknown code gives array", rd, arr_model(18'h1));

        // chip erase
        s0 = n_starts;
        bus_write(18'h0, 8'h30);
        bus_write(18'h0, 8'h30);
        chk("R5 chip start pulses", n_starts - s0, 1);
        chk("R5 chip kind", s_kind, 2);
        chk("R5 chip addr", s_addr, 0);
        chk("R10 busy after start", busy, 1);
        chk("R11 zero phase first", job_phase, 1);
        bus_read(18'h3, rd, oe);  chk("R12 erase read1", rd, 8'h00);
        chk("R12 status oe", oe, 8'hC0);
        bus_read(18'h3, rd, oe);  chk("R12 erase read2 toggles", rd, 8'h40);
        bus_read(18'h3, rd, oe);  chk("R12 erase read3 toggles", rd, 8'h00);
        s0 = n_starts;
        bus_write(18'h0, 8'h40);
        bus_write(18'h0, 8'h12);
        chk("R10 write while busy ignored", n_starts - s0, 0);
        chk("R10 still busy", busy, 1);
        finish_job(1'b0);
        chk("R11 erase phase second", job_phase, 2);
        chk("R11 busy between phases", busy, 1);
        finish_job(1'b0);
        chk("R13 done clears busy", busy, 0);
        bus_read(18'h22, rd, oe); chk("R13 array after job", rd, arr_model(18'h22));

        // block erase
        s0 = n_starts;
        bus_write(18'h0, 8'h20);
        bus_write(18'h3A123, 8'hD0);
        chk("R6 block start", n_starts - s0, 1);
        chk("R6 block kind", s_kind, 3);
        chk("R6 block addr", s_addr, 18'h3A123);
        finish_job(1'b0);
        finish_job(1'b0);
        chk("R11 block ends after two", busy, 0);

        // program with capture timing
        s0 = n_starts;
        bus_write(18'h0, 8'h40);
        @(negedge clk);
        addr = 18'h2B0C1; din = 8'h00; bus_sel = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        addr = 18'h15555; din = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0; bus_sel = 1'b0; addr = 18'h00777;
        @(negedge clk);
        din = 8'hEE;
        repeat (3) @(negedge clk);
        chk("R7 program start", n_starts - s0, 1);
        chk("R7 program kind", s_kind, 1);
        chk("R7 program phase", s_phase, 3);
        chk("R2 address from pulse start", s_addr, 18'h2B0C1);
        chk("R2 data from pulse end", s_data, 8'h5A);
        bus_read(18'h0, rd, oe);  chk("R12 program poll read1", rd, 8'h80);
        bus_read(18'h0, rd, oe);  chk("R12 program poll read2", rd, 8'hC0);
        finish_job(1'b0);
        chk("R11 program single done", busy, 0);

        // broken pairs
        s0 = n_starts;
        bus_write(18'h0, 8'h90);
        bus_write(18'h0, 8'h30);
        bus_write(18'h0, 8'h77);
        bus_read(18'h0, rd, oe);  chk("R8 bad second gives array", rd, arr_model(18'h0));
        bus_write(18'h0, 8'h20);
        bus_write(18'h0, 8'h30);
        chk("R8 no start on bad pair", n_starts - s0, 0);

        // abort pairs
        s0 = n_starts;
        bus_write(18'h0, 8'h40); bus_write(18'h0, 8'hFF); bus_write(18'h0, 8'hFF);
        bus_write(18'h0, 8'h20); bus_write(18'h0, 8'hFF); bus_write(18'h0, 8'hFF);
        bus_write(18'h0, 8'h30); bus_write(18'h0, 8'hFF); bus_write(18'h0, 8'hFF);
        chk("R9 abort no start", n_starts - s0, 0);
        bus_read(18'h1, rd, oe);  chk("R9 abort gives array", rd, arr_model(18'h1));
        bus_write(18'h0, 8'h90);
        bus_read(18'h1, rd, oe);  chk("R9 commands work after abort", rd, 8'h3C);

        // failure handling
        bus_write(18'h0, 8'h40);
        bus_write(18'h100, 8'h33);
        finish_job(1'b1);
        chk("R13 fail raised", fail, 1);
        chk("R13 fail not busy", busy, 0);
        s0 = n_starts;
        bus_write(18'h0, 8'h30); bus_write(18'h0, 8'h30);
        chk("R13 writes ignored while failed", n_starts - s0, 0);
        chk("R13 fail held", fail, 1);
        bus_write(18'h0, 8'hFF); bus_write(18'h0, 8'hFF);
        chk("R13 FF pair clears fail", fail, 0);
        bus_write(18'h0, 8'h90);
        bus_read(18'h0, rd, oe);  chk("R13 commands after clear", rd, 8'hC2);
        bus_write(18'h0, 8'h00);

        // supply low
        @(negedge clk); vpp_hi = 1'b0;
        bus_write(18'h0, 8'h90);
        bus_read(18'h0, rd, oe);  chk("R1 write ignored with supply low", rd, arr_model(18'h0));
        @(negedge clk); vpp_hi = 1'b1;
        bus_read(18'h0, rd, oe);  chk("R1 still array after supply up", rd, arr_model(18'h0));
        bus_write(18'h0, 8'h40);
        bus_write(18'h44, 8'h01);
        chk("R1 job running", busy, 1);
        @(negedge clk); vpp_hi = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 supply low drops job", busy, 0);
        vpp_hi = 1'b1;
        bus_read(18'h9, rd, oe);  chk("R1 array after supply drop", rd, arr_model(18'h9));

        // random command pairs
        for (int it = 0; it < 150; it++) begin
            logic [7:0]  c1, c2;
            logic [17:0] a2, ra;
            logic [1:0]  ek;
            int          b0;
            case ($urandom % 6)
                0: c1 = 8'h00; 1: c1 = 8'h90; 2: c1 = 8'h30;
                3: c1 = 8'h20; 4: c1 = 8'h40; default: c1 = 8'($urandom);
            endcase
            case ($urandom % 6)
                0: c2 = 8'h30; 1: c2 = 8'hD0; 2: c2 = 8'hFF;
                3: c2 = 8'h00; 4: c2 = 8'h90; default: c2 = 8'($urandom);
            endcase
            a2 = 18'($urandom);
            ra = 18'($urandom) | 18'h4;
            b0 = n_starts;
            bus_write(18'($urandom), c1);
            bus_write(a2, c2);
            ek = 2'd0;
            if (c1 == 8'h30 && c2 == 8'h30)      ek = 2'd2;
            else if (c1 == 8'h20 && c2 == 8'hD0) ek = 2'd3;
            else if (c1 == 8'h40 && c2 != 8'hFF) ek = 2'd1;
            chk("R8 random pair start count", n_starts - b0, (ek != 2'd0) ? 1 : 0);
            if (ek != 2'd0) begin
                chk("R8 random pair kind", s_kind, ek);
                if (ek != 2'd2) chk("R8 random pair addr", s_addr, a2);
                if (ek == 2'd1) chk("R8 random pair data", s_data, c2);
                if (ek != 2'd1) finish_job(1'b0);
                finish_job(1'b0);
                chk("R8 random job ends", busy, 0);
            end else begin
                bus_write(18'h0, 8'hFF);
                bus_write(18'h0, 8'hFF);
            end
            bus_read(ra, rd, oe);
            chk("R8 random array read", rd, arr_model(ra));
        end

        fin = 1;
        summary();
        $finish;
    end
endmodule